// File: doc/BRIEF.md
# Glyph Blit Parameter Generator

This block prepares the argument set for one bit-block copy that paints a single character glyph into a destination bitmap. Each request carries five things: a character entry word, the character's pixel width, the base address of the font bitmap area, the current destination bit position and the destination base address. The line height and the destination line pitch travel with the request unchanged.

The entry word packs a glyph offset in its low bits and two kern flags in its top two bits. The block decodes these flags, widens the copy by one column for each set flag and moves the destination start one bit to the left when the leading flag is set. It adds the offset to the 32-bit font base, carrying across the two halves of the address. It then splits the adjusted destination position into a signed word step, which it adds to the 32-bit destination base, and a bit offset inside the word.

Requests enter through a valid/ready handshake. One cycle after acceptance the results appear as a registered bundle with its own valid/ready handshake. The copy itself and address translation are done elsewhere.

Top module: `glyph_blit_param`

## Requirements
- R1: The glyph offset is entry bits [13:0]. The source address {out_src_hi,out_src_lo} equals {req_font_hi,req_font_lo} plus that offset, taken modulo 2^32, so a carry out of the low half increments the high half.
- R2: Entry bit 15 is the leading-kern flag and entry bit 14 is the trailing-kern flag. out_copy_w equals req_pix_w plus both flag values, modulo 2^16.
- R3: out_src_pitch always equals out_copy_w, and out_src_bit is always zero.
- R4: The destination start is the signed value req_bit_pos minus the leading-kern flag. out_dst_bit holds its low 4 bits, so a start of -1 gives bit 15.
- R5: {out_dst_hi,out_dst_lo} equals {req_dst_hi,req_dst_lo} plus the start arithmetically shifted right by 4, modulo 2^32. This carries into the high half, and borrows from it when the start is negative.
- R6: out_height and out_dst_pitch equal req_height and req_dst_pitch of the accepted request.
- R7: A request accepted at a clock edge is presented with out_valid high after that edge. The bundle and out_valid stay unchanged while out_valid is high and out_ready is low.
- R8: req_ready is high exactly when out_valid is low or out_ready is high. After reset out_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_entry | input | 16 | Character entry word: kern flags and glyph offset |
| req_pix_w | input | 16 | Glyph pixel width |
| req_font_lo | input | 16 | Font bitmap base, low half |
| req_font_hi | input | 16 | Font bitmap base, high half |
| req_bit_pos | input | 16 | Current destination bit position |
| req_dst_lo | input | 16 | Destination base, low half |
| req_dst_hi | input | 16 | Destination base, high half |
| req_height | input | 16 | Glyph line count |
| req_dst_pitch | input | 16 | Destination bits per line |
| out_valid | output | 1 | Parameter bundle present |
| out_ready | input | 1 | Consumer takes the bundle |
| out_src_lo | output | 16 | Source address, low half |
| out_src_hi | output | 16 | Source address, high half |
| out_src_bit | output | 4 | Source bit offset (zero) |
| out_src_pitch | output | 16 | Source bits per line |
| out_copy_w | output | 16 | Copy width in bits |
| out_height | output | 16 | Copy height in lines |
| out_dst_lo | output | 16 | Destination word address, low half |
| out_dst_hi | output | 16 | Destination word address, high half |
| out_dst_bit | output | 4 | Destination bit offset |
| out_dst_pitch | output | 16 | Destination bits per line |

## Verification
The bench builds the block with its default 16-bit word and 14-bit offset field. With these values the kern flags sit at bits 15 and 14 directly above the offset, and each address half is small enough that directed values can force a carry across the halves on both adders. A zero bit position with the leading flag set can also force a borrow through the full 32-bit destination. Random out_ready toggling exercises the hold and refill paths of the output register.

// File: rtl/glyph_blit_pkg.sv
// Shared defaults and types for the glyph blit parameter generator.
package glyph_blit_pkg;
    localparam int GB_WORD_W = 16;   // machine word width
    localparam int GB_OFS_W  = 14;   // glyph offset field width

    // Kern flags decoded from the top of the entry word
    typedef struct packed {
        logic lead;    // widen on the left, start one bit earlier
        logic trail;   // widen on the right
    } kern_t;
endpackage

// File: rtl/glyph_kern_decode.sv
// Splits a character entry word into glyph offset and kern flags,
// and forms the copy width. Assumes OFS_W <= WORD_W-2 so the flags
// sit above the offset field.
module glyph_kern_decode
    import glyph_blit_pkg::*;
#(
    parameter int WORD_W = GB_WORD_W,
    parameter int OFS_W  = GB_OFS_W
) (
    input  logic [WORD_W-1:0] entry,
    input  logic [WORD_W-1:0] pix_w,
    output logic [OFS_W-1:0]  offset,
    output kern_t             kern,
    output logic [WORD_W-1:0] copy_w
);
    localparam int LEAD_BIT  = WORD_W - 1;
    localparam int TRAIL_BIT = WORD_W - 2;

    // Field extraction
    always_comb begin
        offset     = entry[OFS_W-1:0];
        kern.lead  = entry[LEAD_BIT];
        kern.trail = entry[TRAIL_BIT];
    end

    // Width grows by one column per kern flag
    always_comb begin
        copy_w = pix_w + WORD_W'(kern.lead) + WORD_W'(kern.trail);
    end
endmodule

// File: rtl/glyph_src_addr.sv
// Adds the glyph offset to the two-half font base address, carrying
// from the low half into the high half.
module glyph_src_addr
    import glyph_blit_pkg::*;
#(
    parameter int WORD_W = GB_WORD_W,
    parameter int OFS_W  = GB_OFS_W
) (
    input  logic [WORD_W-1:0] base_lo,
    input  logic [WORD_W-1:0] base_hi,
    input  logic [OFS_W-1:0]  offset,
    output logic [WORD_W-1:0] src_lo,
    output logic [WORD_W-1:0] src_hi
);
    localparam int PAD_W = WORD_W + 1 - OFS_W;

    logic [WORD_W:0] lo_sum;

    // Low-half add with carry, then carry into the high half
    always_comb begin
        lo_sum = {1'b0, base_lo} + {{PAD_W{1'b0}}, offset};
        src_lo = lo_sum[WORD_W-1:0];
        src_hi = base_hi + {{(WORD_W-1){1'b0}}, lo_sum[WORD_W]};
    end
endmodule

// File: rtl/glyph_dst_addr.sv
// Moves the destination bit position left by the lead kern, splits the
// signed result into a word step and a bit offset, and adds the step to
// the two-half destination base. Assumes WORD_W is a power of two.
module glyph_dst_addr
    import glyph_blit_pkg::*;
#(
    parameter int WORD_W = GB_WORD_W
) (
    input  logic [WORD_W-1:0] bit_pos,
    input  logic              lead_kern,
    input  logic [WORD_W-1:0] base_lo,
    input  logic [WORD_W-1:0] base_hi,
    output logic [WORD_W-1:0] dst_lo,
    output logic [WORD_W-1:0] dst_hi,
    output logic [$clog2(WORD_W)-1:0] dst_bit
);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int ADDR_W = 2 * WORD_W;

    logic signed [WORD_W:0]   start_s;
    logic signed [ADDR_W-1:0] start_w;
    logic signed [ADDR_W-1:0] step_s;
    logic        [ADDR_W-1:0] sum;

    // Signed start position, one bit wider than the word
    always_comb begin
        start_s = $signed({1'b0, bit_pos}) - $signed({{WORD_W{1'b0}}, lead_kern});
        start_w = {{(ADDR_W-WORD_W-1){start_s[WORD_W]}}, start_s};
        step_s  = start_w >>> BIT_W;
    end

    // Full-width add of the signed word step to the base
    always_comb begin
        sum     = {base_hi, base_lo} + $unsigned(step_s);
        dst_lo  = sum[WORD_W-1:0];
        dst_hi  = sum[ADDR_W-1:WORD_W];
        dst_bit = start_s[BIT_W-1:0];
    end
endmodule

// File: rtl/glyph_blit_param.sv
// Top of the glyph blit parameter generator. Accepts one character
// request per handshake and presents the registered copy parameters one
// cycle later. A full output stage accepts a new request only in a
// cycle where the consumer takes the current bundle.
module glyph_blit_param
    import glyph_blit_pkg::*;
#(
    parameter int WORD_W = GB_WORD_W,
    parameter int OFS_W  = GB_OFS_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [WORD_W-1:0]         req_entry,
    input  logic [WORD_W-1:0]         req_pix_w,
    input  logic [WORD_W-1:0]         req_font_lo,
    input  logic [WORD_W-1:0]         req_font_hi,
    input  logic [WORD_W-1:0]         req_bit_pos,
    input  logic [WORD_W-1:0]         req_dst_lo,
    input  logic [WORD_W-1:0]         req_dst_hi,
    input  logic [WORD_W-1:0]         req_height,
    input  logic [WORD_W-1:0]         req_dst_pitch,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [WORD_W-1:0]         out_src_lo,
    output logic [WORD_W-1:0]         out_src_hi,
    output logic [$clog2(WORD_W)-1:0] out_src_bit,
    output logic [WORD_W-1:0]         out_src_pitch,
    output logic [WORD_W-1:0]         out_copy_w,
    output logic [WORD_W-1:0]         out_height,
    output logic [WORD_W-1:0]         out_dst_lo,
    output logic [WORD_W-1:0]         out_dst_hi,
    output logic [$clog2(WORD_W)-1:0] out_dst_bit,
    output logic [WORD_W-1:0]         out_dst_pitch
);
    localparam int BIT_W = $clog2(WORD_W);

    logic [OFS_W-1:0]  offset;
    kern_t             kern;
    logic [WORD_W-1:0] copy_w;
    logic [WORD_W-1:0] src_lo, src_hi;
    logic [WORD_W-1:0] dst_lo, dst_hi;
    logic [BIT_W-1:0]  dst_bit;
    logic              accept;

    glyph_kern_decode #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_kern (
        .entry  (req_entry),
        .pix_w  (req_pix_w),
        .offset (offset),
        .kern   (kern),
        .copy_w (copy_w)
    );

    glyph_src_addr #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_src (
        .base_lo (req_font_lo),
        .base_hi (req_font_hi),
        .offset  (offset),
        .src_lo  (src_lo),
        .src_hi  (src_hi)
    );

    glyph_dst_addr #(.WORD_W(WORD_W)) u_dst (
        .bit_pos   (req_bit_pos),
        .lead_kern (kern.lead),
        .base_lo   (req_dst_lo),
        .base_hi   (req_dst_hi),
        .dst_lo    (dst_lo),
        .dst_hi    (dst_hi),
        .dst_bit   (dst_bit)
    );

    // Handshake: room when empty or when the bundle leaves this cycle
    always_comb begin
        req_ready = !out_valid || out_ready;
        accept    = req_valid && req_ready;
    end

    // Output valid flag
    always_ff @(posedge clk) begin
        if (!rst_n)          out_valid <= 1'b0;
        else if (accept)     out_valid <= 1'b1;
        else if (out_ready)  out_valid <= 1'b0;
    end

    // Parameter bundle register, loaded on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_src_lo    <= '0;
            out_src_hi    <= '0;
            out_src_bit   <= '0;
            out_src_pitch <= '0;
            out_copy_w    <= '0;
            out_height    <= '0;
            out_dst_lo    <= '0;
            out_dst_hi    <= '0;
            out_dst_bit   <= '0;
            out_dst_pitch <= '0;
        end else if (accept) begin
            out_src_lo    <= src_lo;
            out_src_hi    <= src_hi;
            out_src_bit   <= '0;
            out_src_pitch <= copy_w;
            out_copy_w    <= copy_w;
            out_height    <= req_height;
            out_dst_lo    <= dst_lo;
            out_dst_hi    <= dst_hi;
            out_dst_bit   <= dst_bit;
            out_dst_pitch <= req_dst_pitch;
        end
    end
endmodule

// File: rtl/glyph_blit_param_chk.sv
// Property checker for glyph_blit_param, attached by bind below.
// Expected values are formed here as whole 32-bit sums rather than
// split halves.
module glyph_blit_param_chk #(
    parameter int WORD_W = 16,
    parameter int OFS_W  = 14
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic [WORD_W-1:0]         req_entry,
    input logic [WORD_W-1:0]         req_pix_w,
    input logic [WORD_W-1:0]         req_font_lo,
    input logic [WORD_W-1:0]         req_font_hi,
    input logic [WORD_W-1:0]         req_bit_pos,
    input logic [WORD_W-1:0]         req_dst_lo,
    input logic [WORD_W-1:0]         req_dst_hi,
    input logic [WORD_W-1:0]         req_height,
    input logic [WORD_W-1:0]         req_dst_pitch,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [WORD_W-1:0]         out_src_lo,
    input logic [WORD_W-1:0]         out_src_hi,
    input logic [$clog2(WORD_W)-1:0] out_src_bit,
    input logic [WORD_W-1:0]         out_src_pitch,
    input logic [WORD_W-1:0]         out_copy_w,
    input logic [WORD_W-1:0]         out_height,
    input logic [WORD_W-1:0]         out_dst_lo,
    input logic [WORD_W-1:0]         out_dst_hi,
    input logic [$clog2(WORD_W)-1:0] out_dst_bit,
    input logic [WORD_W-1:0]         out_dst_pitch
);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int ADDR_W = 2 * WORD_W;

    logic                     acc;
    logic [WORD_W-1:0]        exp_w;
    logic signed [ADDR_W-1:0] exp_start;
    logic [ADDR_W-1:0]        exp_src;
    logic [ADDR_W-1:0]        exp_dst;

    // Expected values from the request ports
    always_comb begin
        acc       = req_valid && req_ready;
        exp_w     = req_pix_w + WORD_W'(req_entry[WORD_W-1]) + WORD_W'(req_entry[WORD_W-2]);
        exp_start = $signed({{WORD_W{1'b0}}, req_bit_pos}) - $signed(ADDR_W'(req_entry[WORD_W-1]));
        exp_src   = {req_font_hi, req_font_lo} + ADDR_W'(req_entry[OFS_W-1:0]);
        exp_dst   = {req_dst_hi, req_dst_lo} + $unsigned(exp_start >>> BIT_W);
    end

    a_r1_src_addr: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> {out_src_hi, out_src_lo} == $past(exp_src));
    a_r2_copy_width: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_copy_w == $past(exp_w));
    a_r3_src_pitch: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_src_pitch == out_copy_w) && (out_src_bit == '0));
    a_r4_dst_bit: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_dst_bit == $past(exp_start[BIT_W-1:0]));
    a_r5_dst_addr: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> {out_dst_hi, out_dst_lo} == $past(exp_dst));
    a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_height == $past(req_height)) && (out_dst_pitch == $past(req_dst_pitch)));
    a_r7_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_src_lo) && $stable(out_src_hi)
            && $stable(out_copy_w) && $stable(out_dst_lo) && $stable(out_dst_hi)
            && $stable(out_dst_bit) && $stable(out_height) && $stable(out_dst_pitch));
    a_r8_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !req_ready);
endmodule

bind glyph_blit_param glyph_blit_param_chk #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/glyph_blit_param_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference queue compared with the design on every clock.
module glyph_blit_param_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [W-1:0] req_entry = '0, req_pix_w = '0, req_font_lo = '0, req_font_hi = '0;
    logic [W-1:0] req_bit_pos = '0, req_dst_lo = '0, req_dst_hi = '0;
    logic [W-1:0] req_height = '0, req_dst_pitch = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [W-1:0] out_src_lo, out_src_hi, out_src_pitch, out_copy_w, out_height;
    logic [W-1:0] out_dst_lo, out_dst_hi, out_dst_pitch;
    logic [3:0]   out_src_bit, out_dst_bit;

    always #2.5 clk = ~clk;

    glyph_blit_param u_glyph_blit_param (.*);

    typedef struct packed {
        logic [31:0] src;
        logic [15:0] copy_w;
        logic [31:0] dst;
        logic [3:0]  dbit;
        logic [15:0] height;
        logic [15:0] pitch;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cycles   = 0;
    bit   acc_seen = 0;
    bit   bp_mode  = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference arithmetic from the requirements
    function automatic exp_t model(input logic [15:0] e, pw, fl, fh, bp, dl, dh, h, p);
        exp_t r;
        int lk, rk, start, step;
        longint s, d;
        lk = int'(e[15]);
        rk = int'(e[14]);
        s = longint'({fh, fl}) + longint'(e[13:0]);
        r.src = s[31:0];
        r.copy_w = 16'((int'(pw) + lk + rk) & 16'hFFFF);
        start = int'(bp) - lk;
        step = start >>> 4;
        r.dbit = 4'(start & 15);
        d = longint'({dh, dl}) + longint'(step);
        r.dst = d[31:0];
        r.height = h;
        r.pitch = p;
        return r;
    endfunction

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Per-clock comparison and model update
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
            finish_up();
        end
        if (!rst_n) begin
            q.delete();
        end else begin
            chk("R8 req_ready", req_ready, (q.size() == 0) || out_ready);
            chk("R7 out_valid", out_valid, q.size() != 0);
            if (out_valid && q.size() != 0) begin
                chk("R1 src addr", {out_src_hi, out_src_lo}, q[0].src);
                chk("R2 copy width", out_copy_w, q[0].copy_w);
                chk("R3 src pitch", out_src_pitch, q[0].copy_w);
                chk("R3 src bit", out_src_bit, 0);
                chk("R4 dst bit", out_dst_bit, q[0].dbit);
                chk("R5 dst addr", {out_dst_hi, out_dst_lo}, q[0].dst);
                chk("R6 height", out_height, q[0].height);
                chk("R6 dst pitch", out_dst_pitch, q[0].pitch);
            end
            if (out_valid && out_ready && q.size() != 0) void'(q.pop_front());
            if (req_valid && req_ready) begin
                q.push_back(model(req_entry, req_pix_w, req_font_lo, req_font_hi,
                                  req_bit_pos, req_dst_lo, req_dst_hi, req_height, req_dst_pitch));
                acc_seen = 1;
            end
        end
    end

    // Consumer: always ready, or random back-pressure (R7 hold)
    always @(negedge clk) begin
        if (bp_mode) out_ready = 1'($urandom_range(0, 1));
        else         out_ready = 1'b1;
    end

    task automatic send(input logic [15:0] e, pw, fl, fh, bp, dl, dh, h, p);
        @(negedge clk);
        req_entry = e; req_pix_w = pw; req_font_lo = fl; req_font_hi = fh;
        req_bit_pos = bp; req_dst_lo = dl; req_dst_hi = dh;
        req_height = h; req_dst_pitch = p;
        acc_seen = 0;
        req_valid = 1'b1;
        do @(negedge clk); while (!acc_seen);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        chk("R8 reset out_valid", out_valid, 0);
        chk("R8 reset req_ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 no kern, one each, both
        send(16'h0012, 16'd9,  16'h1000, 16'h0002, 16'd37, 16'h4000, 16'h0001, 16'd12, 16'd640);
        send(16'h8012, 16'd9,  16'h1000, 16'h0002, 16'd37, 16'h4000, 16'h0001, 16'd12, 16'd640);
        send(16'h4012, 16'd9,  16'h1000, 16'h0002, 16'd37, 16'h4000, 16'h0001, 16'd12, 16'd640);
        send(16'hC3FF, 16'd15, 16'h1000, 16'h0002, 16'd48, 16'h4000, 16'h0001, 16'd7,  16'd1024);
        // R1 carry into high half, and wrap of the whole address
        send(16'h0020, 16'd8,  16'hFFF0, 16'h0005, 16'd0,  16'h0000, 16'h0000, 16'd5,  16'd16);
        send(16'h3FFF, 16'd8,  16'hFFFF, 16'hFFFF, 16'd0,  16'h0000, 16'h0000, 16'd5,  16'd16);
        // R4/R5: start of -1 borrows from the high destination half
        send(16'h8001, 16'd4,  16'h0000, 16'h0000, 16'd0,  16'h0000, 16'h0003, 16'd9,  16'd32);
        // R5: word step carries into the high destination half
        send(16'h0001, 16'd4,  16'h0000, 16'h0000, 16'hFFFF, 16'hFFF8, 16'h0007, 16'd9, 16'd32);
        // R2: width wraps at 16 bits
        send(16'hC000, 16'hFFFF, 16'h0000, 16'h0000, 16'd16, 16'h0100, 16'h0000, 16'd1, 16'd8);
        // R7/R8 under random back-pressure, back-to-back random traffic
        bp_mode = 1;
        for (int i = 0; i < 400; i++) begin
            send(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
        end
        bp_mode = 0;
        repeat (6) @(negedge clk);
        chk("R7 drained", q.size(), 0);
        finish_up();
    end
endmodule